// File: doc/BRIEF.md
# Alternate Bus Master Arbitration Requester

This block sits beside a secondary bus master, for example a DMA engine, and gets bus ownership from a processor for it. The local side raises a level request, sees an ownership flag once the bus is its own, and pulses a completion input when it has finished. On the bus side the block pulls a shared, wire-ORed request line low. It waits for the processor's grant. It then waits for the bus to go quiet and claims mastership by pulling the shared acknowledge line low for as long as it owns the bus.

The block only claims the bus when four conditions hold in the same sampled cycle: grant is present, address strobe is inactive, data acknowledge is inactive, and no other master holds the acknowledge line. Every bus input is asynchronous and passes through a two-flop synchronizer before it is used. A static mode input selects a two-wire scheme. In that scheme request and acknowledge are merged onto the request line and the acknowledge pull stays off.

All bus lines are active-low. The two bus outputs are pull enables: a 1 means "drive the line low" and a 0 means "release it", so the block can share a line with other open-drain drivers. The block has no data stream, so it has no valid/ready interface: the local side is a plain level request and ownership handshake. The mode input is expected to stay static while the block is away from its idle state.

Top module: `altmaster_req`

## Requirements
- R1: While reset is low, and in the first cycle after it, `bus_req_pull_o`, `bus_ack_pull_o` and `loc_owned_o` are all 0.
- R2: In either mode, `bus_req_pull_o` is 1 on the clock edge after `loc_req_i` is seen high in the idle state. It stays 1 while the block waits for grant and for a quiet bus.
- R3: Ownership (`loc_owned_o` rising) happens only after the synchronized samples show, all in the same cycle: grant low, address strobe high, data acknowledge high and the foreign acknowledge line high. If any one of these is active, ownership never starts.
- R4: In three-wire mode (`two_wire_i`=0), `bus_req_pull_o` is 0 in every cycle where `bus_ack_pull_o` is 1. The request line is dropped when acknowledge starts.
- R5: Once owned, `loc_owned_o` stays 1, and in three-wire mode `bus_ack_pull_o` stays 1, until `loc_done_i` is seen high. In three-wire mode `bus_ack_pull_o` equals `loc_owned_o`.
- R6: A `loc_done_i` pulse during ownership clears `loc_owned_o` and `bus_ack_pull_o` on the next edge. The block is idle one edge after that, so a still-high `loc_req_i` raises `bus_req_pull_o` again on the third edge after the pulse.
- R7: In two-wire mode (`two_wire_i`=1), `bus_ack_pull_o` is always 0. `bus_req_pull_o` is 1 whenever the block is requesting or owns the bus.
- R8: If `loc_req_i` falls before ownership, the block returns to idle and releases its request. This wins over a bus-quiet indication seen in the same cycle.
- R9: A change on any bus input affects the state only after two synchronizer flops. A quiet bus that appears just after one edge gives ownership on the third edge, not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| two_wire_i | input | 1 | 1 selects the merged two-wire scheme |
| loc_req_i | input | 1 | Local level request for bus ownership |
| loc_done_i | input | 1 | Local pulse: ownership no longer needed |
| loc_owned_o | output | 1 | Local side currently owns the bus |
| bus_grant_n_i | input | 1 | Processor grant, active low, asynchronous |
| bus_as_n_i | input | 1 | Address strobe, active low, asynchronous |
| bus_dtack_n_i | input | 1 | Data transfer acknowledge, active low, asynchronous |
| bus_ack_n_i | input | 1 | Shared grant-acknowledge line as seen on the bus, active low |
| bus_req_pull_o | output | 1 | 1 pulls the shared request line low |
| bus_ack_pull_o | output | 1 | 1 pulls the shared acknowledge line low |

## Verification
Two functions can fall in the same cycle. One is the local side withdrawing its request; the other is the synchronized samples first showing a quiet, granted bus. The bench provokes this by releasing address strobe just after an edge and dropping the local request exactly two edges later, which is the cycle the quiet sample reaches the state logic. It passes only if the block goes back to idle with both pulls released and never claims ownership afterwards.

// File: rtl/arb_pkg.sv
package arb_pkg;
  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_REQUEST = 3'd1,
    ST_WAIT    = 3'd2,
    ST_OWN     = 3'd3,
    ST_RELEASE = 3'd4
  } arb_state_e;

  localparam int BUS_IN_W = 4;
  localparam int IX_GRANT = 0;
  localparam int IX_AS    = 1;
  localparam int IX_DTACK = 2;
  localparam int IX_ACK   = 3;
endpackage

// File: rtl/arb_sync.sv
module arb_sync #(
  parameter int W = 4,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) chain[s] <= RST_VAL;
          else        chain[s] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) chain[s] <= RST_VAL;
          else        chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/arb_idle_check.sv
module arb_idle_check
  import arb_pkg::*;
(
  input  logic [BUS_IN_W-1:0] sync_n_i,
  output logic                granted_o,
  output logic                bus_free_o
);
  logic as_quiet, dtack_quiet, ack_quiet;

  always_comb begin
    granted_o   = ~sync_n_i[IX_GRANT];
    as_quiet    =  sync_n_i[IX_AS];
    dtack_quiet =  sync_n_i[IX_DTACK];
    ack_quiet   =  sync_n_i[IX_ACK];
    bus_free_o  = granted_o & as_quiet & dtack_quiet & ack_quiet;
  end
endmodule

// File: rtl/arb_fsm.sv
module arb_fsm
  import arb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic loc_req_i,
  input  logic loc_done_i,
  input  logic granted_i,
  input  logic bus_free_i,
  output logic req_int_o,
  output logic ack_int_o
);
  arb_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (loc_req_i) state_d = ST_REQUEST;
      ST_REQUEST: begin
        if (!loc_req_i)     state_d = ST_IDLE;
        else if (granted_i) state_d = ST_WAIT;
      end
      ST_WAIT: begin
        if (!loc_req_i)      state_d = ST_IDLE;
        else if (bus_free_i) state_d = ST_OWN;
        else if (!granted_i) state_d = ST_REQUEST;
      end
      ST_OWN:     if (loc_done_i) state_d = ST_RELEASE;
      ST_RELEASE: state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign req_int_o = (state_q == ST_REQUEST) || (state_q == ST_WAIT);
  assign ack_int_o = (state_q == ST_OWN);

  // R8: a withdrawn local request is never followed by ownership
  p_withdraw_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_int_o && !loc_req_i) |=> !ack_int_o);

  // R6: after ownership ends the machine passes through idle
  p_release_to_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ack_int_o) |=> (!ack_int_o && !req_int_o));
endmodule

// File: rtl/altmaster_req.sv
module altmaster_req
  import arb_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic two_wire_i,
  input  logic loc_req_i,
  input  logic loc_done_i,
  output logic loc_owned_o,
  input  logic bus_grant_n_i,
  input  logic bus_as_n_i,
  input  logic bus_dtack_n_i,
  input  logic bus_ack_n_i,
  output logic bus_req_pull_o,
  output logic bus_ack_pull_o
);
  logic [BUS_IN_W-1:0] raw_n, sync_n;
  logic granted, bus_free, req_int, ack_int;

  always_comb begin
    raw_n           = '1;
    raw_n[IX_GRANT] = bus_grant_n_i;
    raw_n[IX_AS]    = bus_as_n_i;
    raw_n[IX_DTACK] = bus_dtack_n_i;
    raw_n[IX_ACK]   = bus_ack_n_i;
  end

  arb_sync #(.W(BUS_IN_W), .STAGES(SYNC_STAGES), .RST_VAL('1)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (raw_n),
    .q_o   (sync_n)
  );

  arb_idle_check u_idle (
    .sync_n_i   (sync_n),
    .granted_o  (granted),
    .bus_free_o (bus_free)
  );

  arb_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .loc_req_i  (loc_req_i),
    .loc_done_i (loc_done_i),
    .granted_i  (granted),
    .bus_free_i (bus_free),
    .req_int_o  (req_int),
    .ack_int_o  (ack_int)
  );

  always_comb begin
    loc_owned_o = ack_int;
    if (two_wire_i) begin
      bus_req_pull_o = req_int | ack_int;
      bus_ack_pull_o = 1'b0;
    end else begin
      bus_req_pull_o = req_int;
      bus_ack_pull_o = ack_int;
    end
  end

  // R3: ownership starts only after all four quiet conditions were sampled together
  p_claim_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(loc_owned_o) |-> $past(!sync_n[IX_GRANT] && sync_n[IX_AS]
                                 && sync_n[IX_DTACK] && sync_n[IX_ACK]));

  // R4: request line dropped while acknowledge is pulled
  p_req_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ack_pull_o |-> !bus_req_pull_o);

  // R5: ownership held until completion is signalled
  p_hold_own_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (loc_owned_o && !loc_done_i) |=> loc_owned_o);

  // R6: completion releases acknowledge on the next edge
  p_done_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (loc_owned_o && loc_done_i) |=> (!loc_owned_o && !bus_ack_pull_o));

  // R7: two-wire mode never touches the acknowledge line
  p_two_wire_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
    two_wire_i |-> !bus_ack_pull_o);

  // R7: two-wire mode keeps the request line pulled during ownership
  p_two_wire_own_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (two_wire_i && loc_owned_o) |-> bus_req_pull_o);
endmodule

// File: tb/sim_altmaster_req.sv
module sim_altmaster_req;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic two_wire = 1'b0, loc_req = 1'b0, loc_done = 1'b0;
  logic grant_n = 1'b1, as_n = 1'b1, dtack_n = 1'b1, ack_n = 1'b1;
  logic owned, req_pull, ack_pull;
  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;

  altmaster_req u0 (
    .clk            (clk),
    .rst_n          (rst_n),
    .two_wire_i     (two_wire),
    .loc_req_i      (loc_req),
    .loc_done_i     (loc_done),
    .loc_owned_o    (owned),
    .bus_grant_n_i  (grant_n),
    .bus_as_n_i     (as_n),
    .bus_dtack_n_i  (dtack_n),
    .bus_ack_n_i    (ack_n),
    .bus_req_pull_o (req_pull),
    .bus_ack_pull_o (ack_pull)
  );

  // vector: {two_wire, as_n, dtack_n, ack_n, expect_owned}
  localparam int NV = 8;
  localparam logic [4:0] VEC [NV] = '{
    5'b0_111_1, 5'b0_011_0, 5'b0_101_0, 5'b0_110_0,
    5'b0_000_0, 5'b1_111_1, 5'b1_011_0, 5'b1_110_0
  };

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: {owned,req_pull,ack_pull} actual=%b expected=%b", req, act, exp);
    end
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    step(3);
    check("R1 in reset", {owned, req_pull, ack_pull}, 3'b000);
    rst_n = 1'b1;
    step(1);
    check("R1 after reset", {owned, req_pull, ack_pull}, 3'b000);

    for (int i = 0; i < NV; i++) begin
      logic ex;
      two_wire = VEC[i][4];
      as_n = VEC[i][3]; dtack_n = VEC[i][2]; ack_n = VEC[i][1];
      ex = VEC[i][0];
      step(3);
      loc_req = 1'b1;
      step(1);
      check("R2 request pulled", {owned, req_pull, ack_pull}, 3'b010);
      grant_n = 1'b0;
      step(8);
      // R3 R4 R7 expected outputs
      check(two_wire ? "R7 vector" : "R3 R4 vector",
            {owned, req_pull, ack_pull},
            {ex, (two_wire ? 1'b1 : ~ex), ex & ~two_wire});
      if (ex) begin
        step(4);
        check("R5 held", {owned, req_pull, ack_pull},
              {1'b1, two_wire, ~two_wire});
        loc_done = 1'b1; loc_req = 1'b0;
        step(1);
        loc_done = 1'b0;
      end else begin
        loc_req = 1'b0;
        step(1);
        check("R8 withdraw", {owned, req_pull, ack_pull}, 3'b000);
      end
      grant_n = 1'b1; as_n = 1'b1; dtack_n = 1'b1; ack_n = 1'b1;
      step(4);
    end

    // R9 / R3: exact synchronizer latency
    two_wire = 1'b0; as_n = 1'b0;
    loc_req = 1'b1; grant_n = 1'b0;
    step(6);
    as_n = 1'b1;
    step(2);
    check("R9 not yet owned", {owned, req_pull, ack_pull}, 3'b010);
    step(1);
    check("R9 owned third edge", {owned, req_pull, ack_pull}, 3'b101);

    // R6: release timing with request still held
    loc_done = 1'b1;
    step(1);
    loc_done = 1'b0;
    check("R6 released", {owned, req_pull, ack_pull}, 3'b000);
    step(1);
    check("R6 idle", {owned, req_pull, ack_pull}, 3'b000);
    step(1);
    check("R6 re-request", {owned, req_pull, ack_pull}, 3'b010);
    loc_req = 1'b0;
    grant_n = 1'b1;
    step(4);

    // R8: withdrawal coincides with quiet bus reaching the state logic
    as_n = 1'b0; loc_req = 1'b1; grant_n = 1'b0;
    step(6);
    check("R8 waiting", {owned, req_pull, ack_pull}, 3'b010);
    as_n = 1'b1;
    step(2);
    loc_req = 1'b0;
    step(1);
    check("R8 collision idle", {owned, req_pull, ack_pull}, 3'b000);
    step(5);
    check("R8 no late claim", {owned, req_pull, ack_pull}, 3'b000);
    grant_n = 1'b1;

    // R3: foreign acknowledge appearing late blocks the claim
    ack_n = 1'b0; loc_req = 1'b1; grant_n = 1'b0;
    step(10);
    check("R3 foreign ack blocks", {owned, req_pull, ack_pull}, 3'b010);
    ack_n = 1'b1;
    step(3);
    check("R3 claim after release", {owned, req_pull, ack_pull}, 3'b101);
    loc_done = 1'b1; loc_req = 1'b0;
    step(1);
    loc_done = 1'b0;
    step(2);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule